// File: doc/BRIEF.md
# Low-Power Mode Sequencer for an 8-bit Microcontroller

This block places a small 8-bit microcontroller core in one of two low-power states and brings it back out. Software writes a strobe that asks for a light sleep (the CPU clock stops while the peripherals keep running) or a deep sleep (the oscillator stops and everything else is frozen). The block turns these requests into three clock enables: one for the CPU, one for the peripherals and one for the oscillator. While the core sleeps, the block also decides what the external bus strobes and the two multiplexed ports drive.

Light sleep ends on any enabled interrupt. Deep sleep ends only on an enabled external interrupt line. A hardware reset ends either state. When deep sleep ends, the oscillator restarts first. The CPU clock stays off for a programmable number of settle cycles before execution resumes.

The core, the oscillator and the memories lie outside the block. The core's own bus drive and its port latches arrive as plain inputs. All outputs are combinational decodes of the registered state, so each transition shows on the pins right after the clock edge that causes it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. At any clock edge where it is low, from any state, the block returns to run. In run, `mode_bits` = 2'b00, all three clock enables are 1, and the bus and port outputs pass the core's drive through unchanged (`p0_out`=`core_p0`, `p0_oe`=`core_p0_oe`, `p2_out`=`core_p2`, `ale_o`=`core_ale`, `psen_o`=`core_psen`).
- R2: In run, a `req_pdown` strobe enters deep sleep at that edge and sets `mode_bits` to 2'b10 (bit 1 = deep sleep). A `req_idle` strobe alone enters light sleep and sets `mode_bits` to 2'b01 (bit 0 = light sleep). If both strobes arrive together, deep sleep wins. Strobes that arrive outside run have no effect.
- R3: In light sleep, `cpu_clk_en` is 0 and `per_clk_en` and `osc_en` are 1.
- R4: In deep sleep, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R5: An external line can wake the core only while `glob_en` is 1 and that line's bit is set in both `int_req` and `int_en`.
- R6: Light sleep returns to run at the first edge where an external wake (R5) or `per_irq` is present. `mode_bits` clears to 2'b00 at that edge.
- R7: Deep sleep ignores `per_irq`. On an external wake (R5), the block enters a settle phase and clears `mode_bits` to 2'b00. The settle phase lasts `settle_cnt`+1 cycles, using the value of `settle_cnt` sampled at the wake edge. During settle, `osc_en` is 1 and `cpu_clk_en` and `per_clk_en` are 0. Run follows the settle phase.
- R8: `ale_o` and `psen_o` are both 1 in light sleep. They are both 0 in deep sleep and during settle.
- R9: In every non-run state, port 0 floats (`p0_oe`=0) when `ext_mem`=1. When `ext_mem`=0, port 0 drives `p0_latch` with `p0_oe`=1.
- R10: In light sleep with `ext_mem`=1, `p2_out` carries `p2_addr`. In every other non-run case, `p2_out` carries `p2_latch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| req_idle | input | 1 | Software strobe requesting light sleep |
| req_pdown | input | 1 | Software strobe requesting deep sleep |
| int_req | input | NINT | External interrupt lines |
| int_en | input | NINT | Per-line interrupt enables |
| glob_en | input | 1 | Global interrupt enable |
| per_irq | input | 1 | Any enabled peripheral interrupt pending |
| settle_cnt | input | CW | Settle length after deep sleep, minus one |
| ext_mem | input | 1 | Code is fetched from external program memory |
| core_ale | input | 1 | Core's address latch strobe |
| core_psen | input | 1 | Core's program fetch strobe |
| core_p0 | input | PW | Core's port 0 drive in run |
| core_p0_oe | input | 1 | Core's port 0 output enable in run |
| core_p2 | input | PW | Core's port 2 drive in run |
| p0_latch | input | PW | Port 0 data latch |
| p2_latch | input | PW | Port 2 data latch |
| p2_addr | input | PW | High address byte held by the core |
| mode_bits | output | 2 | Request bits: bit 0 light sleep, bit 1 deep sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ale_o | output | 1 | Address latch strobe pin |
| psen_o | output | 1 | Program fetch strobe pin |
| p0_out | output | PW | Port 0 data |
| p0_oe | output | 1 | Port 0 output enable |
| p2_out | output | PW | Port 2 data |

## Verification
The bench targets the following corner cases:
- Both request strobes in the same cycle. A design with the wrong priority would enter light sleep.
- Strobes arriving while the core already sleeps. A design that ignored the state would retrigger, or flip deep sleep into light sleep.
- A peripheral interrupt during deep sleep. A design that treated it as a wake would restart the clocks early.
- External lines with either enable cleared. A missing enable term would wake the core spuriously.
- Settle lengths of zero and of several cycles. Here an off-by-one in the counter changes the cycle in which `cpu_clk_en` rises.
- Reset during deep sleep and during settle, which must reach run directly.
- Port behaviour under both program-memory sources. A swapped multiplexer would drive port 0 while it should float, or put the address on port 2 in deep sleep.

// File: rtl/pmc_pkg.sv
// Package: shared state encoding for the low-power mode sequencer.
// Assumes: the two-bit encoding is consumed only inside this block.
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_IDLE   = 2'd1,
        PM_DOWN   = 2'd2,
        PM_SETTLE = 2'd3
    } pm_state_t;
endpackage

// File: rtl/pmc_wake.sv
// Module: wake qualification. Combines the external lines with their
// individual enables and the global enable. It also forms the wider wake
// that ends light sleep. Assumes the inputs are already synchronous to clk.
module pmc_wake #(
    parameter int NINT = 2
) (
    input  logic [NINT-1:0] int_req,
    input  logic [NINT-1:0] int_en,
    input  logic            glob_en,
    input  logic            per_irq,
    output logic            ext_wake,
    output logic            any_wake
);
    logic [NINT-1:0] line_ok;

    // One qualified bit per external line.
    for (genvar i = 0; i < NINT; i++) begin : g_line
        assign line_ok[i] = int_req[i] & int_en[i];
    end

    // External wake needs the global enable; light sleep also accepts peripherals.
    always_comb begin
        ext_wake = glob_en & (|line_ok);
        any_wake = ext_wake | per_irq;
    end
endmodule

// File: rtl/pmc_fsm.sv
// Module: mode state machine, settle counter, request bits and clock enables.
// Assumes the request strobes last one cycle. Strobes outside run are dropped.
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_idle,
    input  logic          req_pdown,
    input  logic          ext_wake,
    input  logic          any_wake,
    input  logic [CW-1:0] settle_cnt,
    output pm_state_t     state,
    output logic [1:0]    mode_bits,
    output logic          cpu_clk_en,
    output logic          per_clk_en,
    output logic          osc_en
);
    logic [CW-1:0] cnt_q;

    // State, settle counter and request bits advance together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PM_RUN;
            mode_bits <= 2'b00;
            cnt_q     <= '0;
        end else begin
            case (state)
                PM_RUN: begin
                    if (req_pdown) begin
                        state     <= PM_DOWN;
                        mode_bits <= 2'b10;
                    end else if (req_idle) begin
                        state     <= PM_IDLE;
                        mode_bits <= 2'b01;
                    end
                end
                PM_IDLE: begin
                    if (any_wake) begin
                        state     <= PM_RUN;
                        mode_bits <= 2'b00;
                    end
                end
                PM_DOWN: begin
                    if (ext_wake) begin
                        state     <= PM_SETTLE;
                        mode_bits <= 2'b00;
                        cnt_q     <= settle_cnt;
                    end
                end
                default: begin
                    if (cnt_q == '0) begin
                        state <= PM_RUN;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // Clock enables decoded from the current state.
    always_comb begin
        cpu_clk_en = (state == PM_RUN);
        per_clk_en = (state == PM_RUN) || (state == PM_IDLE);
        osc_en     = (state != PM_DOWN);
    end
endmodule

// File: rtl/pmc_pinmux.sv
// Module: pin-state multiplexer. Selects the bus strobe and port drive for each
// mode and program-memory source. Settle behaves like deep sleep on the pins.
module pmc_pinmux
    import pmc_pkg::*;
#(
    parameter int PW = 8
) (
    input  pm_state_t     state,
    input  logic          ext_mem,
    input  logic          core_ale,
    input  logic          core_psen,
    input  logic [PW-1:0] core_p0,
    input  logic          core_p0_oe,
    input  logic [PW-1:0] core_p2,
    input  logic [PW-1:0] p0_latch,
    input  logic [PW-1:0] p2_latch,
    input  logic [PW-1:0] p2_addr,
    output logic          ale_o,
    output logic          psen_o,
    output logic [PW-1:0] p0_out,
    output logic          p0_oe,
    output logic [PW-1:0] p2_out
);
    // Pin selection per state.
    always_comb begin
        ale_o  = core_ale;
        psen_o = core_psen;
        p0_out = core_p0;
        p0_oe  = core_p0_oe;
        p2_out = core_p2;
        if (state != PM_RUN) begin
            ale_o  = (state == PM_IDLE);
            psen_o = (state == PM_IDLE);
            p0_out = p0_latch;
            p0_oe  = !ext_mem;
            p2_out = (state == PM_IDLE && ext_mem) ? p2_addr : p2_latch;
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: top of the low-power mode sequencer. Wires wake qualification,
// state machine and pin multiplexer together. Assumes every input is
// synchronous to clk and that clk itself is never gated by this block.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NINT = 2,
    parameter int PW   = 8,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_idle,
    input  logic            req_pdown,
    input  logic [NINT-1:0] int_req,
    input  logic [NINT-1:0] int_en,
    input  logic            glob_en,
    input  logic            per_irq,
    input  logic [CW-1:0]   settle_cnt,
    input  logic            ext_mem,
    input  logic            core_ale,
    input  logic            core_psen,
    input  logic [PW-1:0]   core_p0,
    input  logic            core_p0_oe,
    input  logic [PW-1:0]   core_p2,
    input  logic [PW-1:0]   p0_latch,
    input  logic [PW-1:0]   p2_latch,
    input  logic [PW-1:0]   p2_addr,
    output logic [1:0]      mode_bits,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            osc_en,
    output logic            ale_o,
    output logic            psen_o,
    output logic [PW-1:0]   p0_out,
    output logic            p0_oe,
    output logic [PW-1:0]   p2_out
);
    logic      ext_wake;
    logic      any_wake;
    pm_state_t state;

    pmc_wake #(.NINT(NINT)) u_wake (
        .int_req  (int_req),
        .int_en   (int_en),
        .glob_en  (glob_en),
        .per_irq  (per_irq),
        .ext_wake (ext_wake),
        .any_wake (any_wake)
    );

    pmc_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_idle   (req_idle),
        .req_pdown  (req_pdown),
        .ext_wake   (ext_wake),
        .any_wake   (any_wake),
        .settle_cnt (settle_cnt),
        .state      (state),
        .mode_bits  (mode_bits),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .osc_en     (osc_en)
    );

    pmc_pinmux #(.PW(PW)) u_pins (
        .state      (state),
        .ext_mem    (ext_mem),
        .core_ale   (core_ale),
        .core_psen  (core_psen),
        .core_p0    (core_p0),
        .core_p0_oe (core_p0_oe),
        .core_p2    (core_p2),
        .p0_latch   (p0_latch),
        .p2_latch   (p2_latch),
        .p2_addr    (p2_addr),
        .ale_o      (ale_o),
        .psen_o     (psen_o),
        .p0_out     (p0_out),
        .p0_oe      (p0_oe),
        .p2_out     (p2_out)
    );
endmodule

// File: rtl/pmc_checker.sv
// Module: property checker for the mode sequencer, attached through bind.
// Assumes it sees only the top-level ports.
module pmc_checker #(
    parameter int NINT = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NINT-1:0] int_req,
    input logic [NINT-1:0] int_en,
    input logic            glob_en,
    input logic            per_irq,
    input logic            ext_mem,
    input logic [1:0]      mode_bits,
    input logic            cpu_clk_en,
    input logic            per_clk_en,
    input logic            osc_en,
    input logic            ale_o,
    input logic            psen_o,
    input logic            p0_oe
);
    logic ext_ok;
    assign ext_ok = glob_en && ((int_req & int_en) != '0);

    // At most one request bit is ever set (R2).
    p_bits_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_bits));

    // Light sleep gates only the CPU clock (R3).
    p_idle_clocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bits[0] |-> (!cpu_clk_en && per_clk_en && osc_en));

    // Deep sleep gates every clock (R4).
    p_down_clocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bits[1] |-> (!cpu_clk_en && !per_clk_en && !osc_en));

    // Without a qualified external line, deep sleep persists (R5).
    p_down_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits[1] && !ext_ok) |=> mode_bits[1]);

    // Light sleep leaves on any wake, straight to run (R6).
    p_idle_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits[0] && (ext_ok || per_irq)) |=> (mode_bits == 2'b00 && cpu_clk_en));

    // Deep sleep leaves into settle: oscillator on, CPU still stopped (R7).
    p_down_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits[1] && ext_ok) |=> (mode_bits == 2'b00 && osc_en && !cpu_clk_en && !per_clk_en));

    // Bus strobes high in light sleep, low in deep sleep (R8).
    p_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits != 2'b00) |-> (ale_o == mode_bits[0] && psen_o == mode_bits[0]));

    // Port 0 floats while sleeping with external program memory (R9).
    p_p0_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mem && mode_bits != 2'b00) |-> !p0_oe);
endmodule

bind pwr_mode_ctrl pmc_checker #(.NINT(NINT)) u_pmc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_req    (int_req),
    .int_en     (int_en),
    .glob_en    (glob_en),
    .per_irq    (per_irq),
    .ext_mem    (ext_mem),
    .mode_bits  (mode_bits),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .ale_o      (ale_o),
    .psen_o     (psen_o),
    .p0_oe      (p0_oe)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/100ps
// Bench: behavioural reference model of the sequencer, compared on every clock.
module pwr_mode_ctrl_test;
    localparam int NINT = 2;
    localparam int PW   = 8;
    localparam int CW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_idle = 1'b0, req_pdown = 1'b0;
    logic [NINT-1:0] int_req = '0, int_en = '0;
    logic            glob_en = 1'b0, per_irq = 1'b0;
    logic [CW-1:0]   settle_cnt = '0;
    logic            ext_mem = 1'b0;
    logic            core_ale = 1'b0, core_psen = 1'b0, core_p0_oe = 1'b0;
    logic [PW-1:0]   core_p0 = '0, core_p2 = '0, p0_latch = '0, p2_latch = '0, p2_addr = '0;
    logic [1:0]      mode_bits;
    logic            cpu_clk_en, per_clk_en, osc_en, ale_o, psen_o, p0_oe;
    logic [PW-1:0]   p0_out, p2_out;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(.NINT(NINT), .PW(PW), .CW(CW)) uut (.*);

    // Reference model: 0 run, 1 light sleep, 2 deep sleep, 3 settle.
    int m_st  = 0;
    int m_cnt = 0;
    int m_bits = 0;

    always @(posedge clk) begin
        bit ew;
        ew = glob_en && ((int_req & int_en) != 0);
        if (!rst_n) begin
            m_st = 0; m_bits = 0; m_cnt = 0;
        end else if (m_st == 0) begin
            if (req_pdown) begin m_st = 2; m_bits = 2; end
            else if (req_idle) begin m_st = 1; m_bits = 1; end
        end else if (m_st == 1) begin
            if (ew || per_irq) begin m_st = 0; m_bits = 0; end
        end else if (m_st == 2) begin
            if (ew) begin m_st = 3; m_bits = 0; m_cnt = int'(settle_cnt); end
        end else begin
            if (m_cnt == 0) m_st = 0;
            else m_cnt = m_cnt - 1;
        end
    end

    task automatic chk(string tag, string nm, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, 1 ns after the edge.
    always @(posedge clk) begin
        string ct;
        #1;
        if (!done) begin
            ct = (m_st == 0) ? "R1" : (m_st == 1) ? "R3" : (m_st == 2) ? "R4" : "R7";
            chk("R2", "mode_bits", int'(mode_bits), m_bits);
            chk(ct, "cpu_clk_en", int'(cpu_clk_en), int'(m_st == 0));
            chk(ct, "per_clk_en", int'(per_clk_en), int'(m_st <= 1));
            chk(ct, "osc_en", int'(osc_en), int'(m_st != 2));
            if (m_st == 0) begin
                chk("R1", "ale_o", int'(ale_o), int'(core_ale));
                chk("R1", "psen_o", int'(psen_o), int'(core_psen));
                chk("R1", "p0_out", int'(p0_out), int'(core_p0));
                chk("R1", "p0_oe", int'(p0_oe), int'(core_p0_oe));
                chk("R1", "p2_out", int'(p2_out), int'(core_p2));
            end else begin
                chk("R8", "ale_o", int'(ale_o), int'(m_st == 1));
                chk("R8", "psen_o", int'(psen_o), int'(m_st == 1));
                chk("R9", "p0_oe", int'(p0_oe), int'(!ext_mem));
                if (!ext_mem) chk("R9", "p0_out", int'(p0_out), int'(p0_latch));
                chk("R10", "p2_out", int'(p2_out),
                    (m_st == 1 && ext_mem) ? int'(p2_addr) : int'(p2_latch));
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(bit i, bit p);
        req_idle = i; req_pdown = p;
        cyc(1);
        req_idle = 0; req_pdown = 0;
    endtask

    // Directed scenarios; the model supplies expected values every cycle.
    initial begin
        cyc(3);
        chk("R1", "reset mode_bits", int'(mode_bits), 0);
        chk("R1", "reset cpu_clk_en", int'(cpu_clk_en), 1);
        rst_n = 1;
        core_p0 = 8'h3C; core_p0_oe = 1; core_p2 = 8'h81; core_ale = 1;
        p0_latch = 8'hA5; p2_latch = 8'h5A; p2_addr = 8'hC3;
        cyc(2);
        core_psen = 1; core_p0 = 8'h96;
        cyc(2);

        // R3 / R6: light sleep, internal memory, peripheral wake.
        strobe(1, 0);
        chk("R2", "idle bit set", int'(mode_bits), 1);
        cyc(3);
        per_irq = 1; cyc(1); per_irq = 0;
        chk("R6", "idle left on per_irq", int'(mode_bits), 0);
        cyc(2);

        // R5 / R10: light sleep, external memory; blocked wakes first.
        ext_mem = 1;
        strobe(1, 0);
        int_req = 2'b01; int_en = 2'b01; glob_en = 0; cyc(2);
        chk("R5", "no wake without global enable", int'(mode_bits), 1);
        glob_en = 1; int_en = 2'b10; cyc(2);
        chk("R5", "no wake with line disabled", int'(mode_bits), 1);
        strobe(0, 1);
        chk("R2", "strobe ignored in idle", int'(mode_bits), 1);
        int_en = 2'b01; cyc(1);
        chk("R6", "idle left on enabled line", int'(mode_bits), 0);
        int_req = 0; cyc(2);

        // R4 / R7: deep sleep, external memory, settle of 3.
        settle_cnt = 3; int_en = 2'b10;
        strobe(0, 1);
        per_irq = 1; cyc(3); per_irq = 0;
        chk("R7", "per_irq ignored in deep sleep", int'(mode_bits), 2);
        strobe(1, 0);
        chk("R2", "idle strobe ignored in deep sleep", int'(mode_bits), 2);
        int_req = 2'b01; cyc(2);
        chk("R5", "disabled line keeps deep sleep", int'(osc_en), 0);
        int_req = 2'b10; cyc(1); int_req = 0;
        settle_cnt = 9;
        chk("R7", "settle: cpu off", int'(cpu_clk_en), 0);
        cyc(3);
        chk("R7", "settle last cycle", int'(cpu_clk_en), 0);
        cyc(1);
        chk("R7", "run after settle", int'(cpu_clk_en), 1);
        cyc(2);

        // R2 priority, internal memory, settle of 0.
        ext_mem = 0; settle_cnt = 0;
        strobe(1, 1);
        chk("R2", "deep sleep wins", int'(mode_bits), 2);
        cyc(2);
        int_req = 2'b10; cyc(1); int_req = 0;
        chk("R7", "zero settle cycle", int'(cpu_clk_en), 0);
        cyc(1);
        chk("R7", "zero settle done", int'(cpu_clk_en), 1);
        cyc(2);

        // R1: reset during deep sleep and during settle.
        ext_mem = 1; strobe(0, 1); cyc(2);
        rst_n = 0; cyc(1); rst_n = 1;
        chk("R1", "reset leaves deep sleep", int'(cpu_clk_en), 1);
        settle_cnt = 5; strobe(0, 1);
        int_req = 2'b10; cyc(1); int_req = 0; cyc(1);
        rst_n = 0; cyc(1); rst_n = 1;
        chk("R1", "reset leaves settle", int'(cpu_clk_en), 1);
        cyc(3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule